// File: doc/BRIEF.md
# Register Rename Map with Ready Scoreboard

This block holds the speculative mapping from architectural registers to physical registers in an out-of-order core. One logical index space covers both register classes: integer registers take the low indices and floating-point registers follow. Each class has its own map table and its own pool of free physical registers. A ready bit is kept for every physical register of both classes, and a small separate ready scoreboard covers miscellaneous registers.

A rename request allocates the lowest-numbered free physical register of the requested class and installs it as the new mapping. In the same cycle it reports the new index and the displaced old mapping, so that the old mapping can be restored later. Recovery is driven from outside as a stream with one item per cycle. Each item may carry a restore pair (logical register, earlier physical register, earlier valid bit) and a physical register to return to its pool. The sender presents restore pairs youngest first, so the oldest mapping is the one left in the table. Rename, lookup and the ready query are combinational reads of the state. Every update takes effect at the next rising clock edge.

Top module: `register_rename_map`

## Requirements
- R1: An accepted rename of a non-zero logical register returns the lowest-numbered free physical register of its class on `ren_new_phys`, together with the entry held before (`ren_old_phys`, `ren_old_valid`). From the next edge, that register is the mapping (valid) and is no longer free.
- R2: Logical index 0 (integer zero) and index NUM_INT_LOG (floating-point zero) are never renamed. A rename of either returns 0 as new index, 0 as old index and 0 as old valid, and allocates nothing. Set-entry and restore writes to them are ignored, so their lookup stays at index 0, invalid.
- R3: Logical indices below NUM_INT_LOG are integer registers and the rest are floating-point registers. Each class uses its own map table, its own free pool and its own physical numbering from 0.
- R4: After reset, every map entry is index 0 and invalid, every physical register is ready, physical register 0 of each class is reserved (not free), and the free counts are NUM_INT_PHYS-1 and NUM_FP_PHYS-1.
- R5: Allocating a physical register clears its ready bit at the same edge. `rdy_mark_valid` sets the bit of the given class and index; if both act on one bit, the set wins. `rdy_qry_ready` shows the bit combinationally.
- R6: A rename of a non-zero register whose class pool is empty raises `ren_stall` and changes neither the map nor the pool.
- R7: A restore item (`sq_unmap_valid`) writes the given physical index and valid bit into the named logical entry at the next edge. If a restore and a set-entry target the same class in one cycle, the restore is written.
- R8: A return item (`sq_free_valid`) makes the given physical register of the class chosen by `sq_free_fp` free again. Returning physical register 0 has no effect.
- R9: A rename presented in a cycle that also carries a restore item, a return item or a set-entry is refused with `ren_stall` and has no effect.
- R10: A set-entry writes the given physical index as a valid mapping of the named logical register and leaves the free pools unchanged.
- R11: The miscellaneous scoreboard resets to all ready. `misc_clr_valid` clears one bit and `misc_set_valid` sets one bit; if both name the same bit, the set wins. `misc_qry_ready` shows the addressed bit.
- R12: `int_free_cnt` and `fp_free_cnt` always equal the number of free physical registers in each class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_log | input | LW | Logical register to rename |
| ren_stall | output | 1 | Rename refused this cycle |
| ren_new_phys | output | PW | Newly allocated physical index |
| ren_old_phys | output | PW | Physical index displaced by the rename |
| ren_old_valid | output | 1 | Valid bit of the displaced entry |
| lkp_log | input | LW | Logical register to look up |
| lkp_phys | output | PW | Current mapping of `lkp_log` |
| lkp_valid | output | 1 | Valid bit of that mapping |
| set_valid | input | 1 | Direct map write |
| set_log | input | LW | Logical register to write |
| set_phys | input | PW | Physical index to install |
| rdy_mark_valid | input | 1 | Mark a physical register ready |
| rdy_mark_fp | input | 1 | Class of the marked register (1 = floating point) |
| rdy_mark_phys | input | PW | Index of the marked register |
| rdy_qry_fp | input | 1 | Class of the queried register |
| rdy_qry_phys | input | PW | Index of the queried register |
| rdy_qry_ready | output | 1 | Ready bit of the queried register |
| misc_set_valid | input | 1 | Set a miscellaneous ready bit |
| misc_set_idx | input | MW | Bit to set |
| misc_clr_valid | input | 1 | Clear a miscellaneous ready bit |
| misc_clr_idx | input | MW | Bit to clear |
| misc_qry_idx | input | MW | Miscellaneous bit to query |
| misc_qry_ready | output | 1 | Queried miscellaneous ready bit |
| sq_unmap_valid | input | 1 | Restore item present |
| sq_unmap_log | input | LW | Logical register to restore |
| sq_unmap_phys | input | PW | Earlier physical index |
| sq_unmap_pvalid | input | 1 | Earlier valid bit |
| sq_free_valid | input | 1 | Return item present |
| sq_free_fp | input | 1 | Class of the returned register |
| sq_free_phys | input | PW | Physical register returned to the pool |
| int_free_cnt | output | ICW | Free integer physical registers |
| fp_free_cnt | output | FCW | Free floating-point physical registers |

## Verification
Renames are applied to every non-zero register of both classes in turn. This tells a correct lowest-free choice and correct per-class numbering apart from a shared or misordered pool. One integer register is then renamed over and over until its pool runs dry, which exposes a missing or early stall and a free count off by one. Renames of both zero indices and renames that collide with restore, return and set-entry items show whether the refusal and ignore rules change any state. Restores with valid and with invalid earlier entries, a return of register 0, and set/clear collisions on the scoreboards check that the priority rules are applied.

// File: rtl/rrm_pkg.sv
package rrm_pkg;

  // Source that owns a class's map write port in a given cycle.
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_SQUASH = 2'd1,
    WR_SET    = 2'd2,
    WR_RENAME = 2'd3
  } map_wr_src_e;

  // Pools are limited to 64 entries; the arithmetic works on a 64-bit view.
  function automatic logic [6:0] count_ones(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) n = n + 7'(v[i]);
    return n;
  endfunction

  function automatic logic [5:0] lowest_one(input logic [63:0] v);
    logic [5:0] r;
    r = '0;
    for (int i = 63; i >= 0; i--) if (v[i]) r = 6'(i);
    return r;
  endfunction

endpackage

// File: rtl/rrm_free_pool.sv
module rrm_free_pool
  import rrm_pkg::*;
#(
  parameter int N  = 16,
  parameter int PW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          free_en,
  input  logic [PW-1:0] free_idx,
  output logic          empty,
  output logic [PW-1:0] alloc_idx,
  output logic [CW-1:0] cnt
);

  logic [N-1:0] free_q;
  logic [N-1:0] free_d;
  logic         free_ok;

  assign empty     = (free_q == '0);
  assign alloc_idx = PW'(lowest_one(64'(free_q)));
  assign cnt       = CW'(count_ones(64'(free_q)));
  assign free_ok   = free_en && (free_idx != '0) && (int'(free_idx) < N);

  always_comb begin
    free_d = free_q;
    if (alloc) free_d[alloc_idx] = 1'b0;
    if (free_ok) free_d[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) free_q <= {{(N-1){1'b1}}, 1'b0};
    else        free_q <= free_d;
  end

  // R6
  alloc_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !empty);

  // R12
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !free_en) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/rrm_map_table.sv
module rrm_map_table #(
  parameter int N    = 8,
  parameter int IW   = $clog2(N),
  parameter int PWD  = 4,
  parameter int ZERO = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  rd_a_idx,
  output logic [PWD-1:0] rd_a_phys,
  output logic           rd_a_vld,
  input  logic [IW-1:0]  rd_b_idx,
  output logic [PWD-1:0] rd_b_phys,
  output logic           rd_b_vld,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [PWD-1:0] wr_phys,
  input  logic           wr_vld
);

  logic [PWD-1:0] phys_q [N];
  logic [N-1:0]   vld_q;
  logic           wr_ok;

  assign wr_ok = wr_en && (int'(wr_idx) != ZERO) && (int'(wr_idx) < N);

  always_comb begin
    rd_a_phys = '0;
    rd_a_vld  = 1'b0;
    rd_b_phys = '0;
    rd_b_vld  = 1'b0;
    if (int'(rd_a_idx) < N) begin
      rd_a_phys = phys_q[rd_a_idx];
      rd_a_vld  = vld_q[rd_a_idx];
    end
    if (int'(rd_b_idx) < N) begin
      rd_b_phys = phys_q[rd_b_idx];
      rd_b_vld  = vld_q[rd_b_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) phys_q[i] <= '0;
      vld_q <= '0;
    end else if (wr_ok) begin
      phys_q[wr_idx] <= wr_phys;
      vld_q[wr_idx]  <= wr_vld;
    end
  end

  // R10
  map_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (phys_q[$past(wr_idx)] == $past(wr_phys)) && (vld_q[$past(wr_idx)] == $past(wr_vld)));

  // R2
  zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) == ZERO) |=> $stable(phys_q[ZERO]) && $stable(vld_q[ZERO]));

endmodule

// File: rtl/rrm_scoreboard.sv
module rrm_scoreboard #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic [IW-1:0] qry_idx,
  output logic          qry_rdy
);

  logic [N-1:0] rdy_q;
  logic [N-1:0] rdy_d;
  logic         clr_wins;

  assign qry_rdy  = (int'(qry_idx) < N) ? rdy_q[qry_idx] : 1'b0;
  assign clr_wins = clr_en && !(set_en && (set_idx == clr_idx)) && (int'(clr_idx) < N);

  always_comb begin
    rdy_d = rdy_q;
    if (clr_en && int'(clr_idx) < N) rdy_d[clr_idx] = 1'b0;
    if (set_en && int'(set_idx) < N) rdy_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '1;
    else        rdy_q <= rdy_d;
  end

  // R5
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && int'(set_idx) < N) |=> rdy_q[$past(set_idx)]);

  // R5
  rdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wins |=> !rdy_q[$past(clr_idx)]);

endmodule

// File: rtl/register_rename_map.sv
module register_rename_map
  import rrm_pkg::*;
#(
  parameter int NUM_INT_LOG  = 8,
  parameter int NUM_FP_LOG   = 8,
  parameter int NUM_INT_PHYS = 16,
  parameter int NUM_FP_PHYS  = 16,
  parameter int NUM_MISC     = 4,
  parameter int INT_ZERO     = 0,
  parameter int FP_ZERO      = 0,
  localparam int LW  = $clog2(NUM_INT_LOG + NUM_FP_LOG),
  localparam int PW  = $clog2((NUM_INT_PHYS > NUM_FP_PHYS) ? NUM_INT_PHYS : NUM_FP_PHYS),
  localparam int ICW = $clog2(NUM_INT_PHYS + 1),
  localparam int FCW = $clog2(NUM_FP_PHYS + 1),
  localparam int MW  = $clog2(NUM_MISC)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ren_valid,
  input  logic [LW-1:0]  ren_log,
  output logic           ren_stall,
  output logic [PW-1:0]  ren_new_phys,
  output logic [PW-1:0]  ren_old_phys,
  output logic           ren_old_valid,
  input  logic [LW-1:0]  lkp_log,
  output logic [PW-1:0]  lkp_phys,
  output logic           lkp_valid,
  input  logic           set_valid,
  input  logic [LW-1:0]  set_log,
  input  logic [PW-1:0]  set_phys,
  input  logic           rdy_mark_valid,
  input  logic           rdy_mark_fp,
  input  logic [PW-1:0]  rdy_mark_phys,
  input  logic           rdy_qry_fp,
  input  logic [PW-1:0]  rdy_qry_phys,
  output logic           rdy_qry_ready,
  input  logic           misc_set_valid,
  input  logic [MW-1:0]  misc_set_idx,
  input  logic           misc_clr_valid,
  input  logic [MW-1:0]  misc_clr_idx,
  input  logic [MW-1:0]  misc_qry_idx,
  output logic           misc_qry_ready,
  input  logic           sq_unmap_valid,
  input  logic [LW-1:0]  sq_unmap_log,
  input  logic [PW-1:0]  sq_unmap_phys,
  input  logic           sq_unmap_pvalid,
  input  logic           sq_free_valid,
  input  logic           sq_free_fp,
  input  logic [PW-1:0]  sq_free_phys,
  output logic [ICW-1:0] int_free_cnt,
  output logic [FCW-1:0] fp_free_cnt
);

  localparam int IIW = $clog2(NUM_INT_LOG);
  localparam int FIW = $clog2(NUM_FP_LOG);
  localparam int IPW = $clog2(NUM_INT_PHYS);
  localparam int FPW = $clog2(NUM_FP_PHYS);

  // ---- index arithmetic on the shared logical space ----
  function automatic logic log_is_fp(input logic [LW-1:0] l);
    return int'(l) >= NUM_INT_LOG;
  endfunction

  function automatic logic [IIW-1:0] int_loc(input logic [LW-1:0] l);
    return IIW'(l);
  endfunction

  function automatic logic [FIW-1:0] fp_loc(input logic [LW-1:0] l);
    return FIW'(int'(l) - NUM_INT_LOG);
  endfunction

  function automatic logic log_is_zero(input logic [LW-1:0] l);
    return log_is_fp(l) ? (int'(fp_loc(l)) == FP_ZERO) : (int'(int_loc(l)) == INT_ZERO);
  endfunction

  // ---- named internal events ----
  logic ren_is_fp, ren_zero, ren_blocked, pool_empty, ren_go, alloc_int, alloc_fp;
  logic int_empty, fp_empty;
  logic [IPW-1:0] int_alloc_idx;
  logic [FPW-1:0] fp_alloc_idx;

  assign ren_is_fp   = log_is_fp(ren_log);
  assign ren_zero    = log_is_zero(ren_log);
  assign ren_blocked = sq_unmap_valid | sq_free_valid | set_valid;
  assign pool_empty  = ren_is_fp ? fp_empty : int_empty;
  assign ren_stall   = ren_valid & (ren_blocked | (!ren_zero & pool_empty));
  assign ren_go      = ren_valid & !ren_stall & !ren_zero;
  assign alloc_int   = ren_go & !ren_is_fp;
  assign alloc_fp    = ren_go & ren_is_fp;

  // ---- free pools ----
  rrm_free_pool #(.N(NUM_INT_PHYS), .PW(IPW), .CW(ICW)) u_int_pool (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_int),
    .free_en(sq_free_valid & !sq_free_fp), .free_idx(IPW'(sq_free_phys)),
    .empty(int_empty), .alloc_idx(int_alloc_idx), .cnt(int_free_cnt));

  rrm_free_pool #(.N(NUM_FP_PHYS), .PW(FPW), .CW(FCW)) u_fp_pool (
    .clk(clk), .rst_n(rst_n), .alloc(alloc_fp),
    .free_en(sq_free_valid & sq_free_fp), .free_idx(FPW'(sq_free_phys)),
    .empty(fp_empty), .alloc_idx(fp_alloc_idx), .cnt(fp_free_cnt));

  // ---- map write arbitration: restore, then set-entry, then rename ----
  map_wr_src_e    int_wr_src, fp_wr_src;
  logic [IIW-1:0] iw_idx;
  logic [IPW-1:0] iw_phys;
  logic           iw_vld;
  logic [FIW-1:0] fw_idx;
  logic [FPW-1:0] fw_phys;
  logic           fw_vld;

  always_comb begin
    int_wr_src = WR_NONE;
    iw_idx     = int_loc(ren_log);
    iw_phys    = int_alloc_idx;
    iw_vld     = 1'b1;
    if (sq_unmap_valid && !log_is_fp(sq_unmap_log)) begin
      int_wr_src = WR_SQUASH;
      iw_idx     = int_loc(sq_unmap_log);
      iw_phys    = IPW'(sq_unmap_phys);
      iw_vld     = sq_unmap_pvalid;
    end else if (set_valid && !log_is_fp(set_log)) begin
      int_wr_src = WR_SET;
      iw_idx     = int_loc(set_log);
      iw_phys    = IPW'(set_phys);
    end else if (alloc_int) begin
      int_wr_src = WR_RENAME;
    end
  end

  always_comb begin
    fp_wr_src = WR_NONE;
    fw_idx    = fp_loc(ren_log);
    fw_phys   = fp_alloc_idx;
    fw_vld    = 1'b1;
    if (sq_unmap_valid && log_is_fp(sq_unmap_log)) begin
      fp_wr_src = WR_SQUASH;
      fw_idx    = fp_loc(sq_unmap_log);
      fw_phys   = FPW'(sq_unmap_phys);
      fw_vld    = sq_unmap_pvalid;
    end else if (set_valid && log_is_fp(set_log)) begin
      fp_wr_src = WR_SET;
      fw_idx    = fp_loc(set_log);
      fw_phys   = FPW'(set_phys);
    end else if (alloc_fp) begin
      fp_wr_src = WR_RENAME;
    end
  end

  // ---- map tables ----
  logic [IPW-1:0] i_ra_phys, i_rb_phys;
  logic           i_ra_vld, i_rb_vld;
  logic [FPW-1:0] f_ra_phys, f_rb_phys;
  logic           f_ra_vld, f_rb_vld;

  rrm_map_table #(.N(NUM_INT_LOG), .IW(IIW), .PWD(IPW), .ZERO(INT_ZERO)) u_int_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(int_loc(ren_log)), .rd_a_phys(i_ra_phys), .rd_a_vld(i_ra_vld),
    .rd_b_idx(int_loc(lkp_log)), .rd_b_phys(i_rb_phys), .rd_b_vld(i_rb_vld),
    .wr_en(int_wr_src != WR_NONE), .wr_idx(iw_idx), .wr_phys(iw_phys), .wr_vld(iw_vld));

  rrm_map_table #(.N(NUM_FP_LOG), .IW(FIW), .PWD(FPW), .ZERO(FP_ZERO)) u_fp_map (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(fp_loc(ren_log)), .rd_a_phys(f_ra_phys), .rd_a_vld(f_ra_vld),
    .rd_b_idx(fp_loc(lkp_log)), .rd_b_phys(f_rb_phys), .rd_b_vld(f_rb_vld),
    .wr_en(fp_wr_src != WR_NONE), .wr_idx(fw_idx), .wr_phys(fw_phys), .wr_vld(fw_vld));

  // ---- rename and lookup results ----
  always_comb begin
    ren_new_phys  = '0;
    ren_old_phys  = '0;
    ren_old_valid = 1'b0;
    if (!ren_zero) begin
      if (ren_is_fp) begin
        ren_new_phys  = PW'(fp_alloc_idx);
        ren_old_phys  = PW'(f_ra_phys);
        ren_old_valid = f_ra_vld;
      end else begin
        ren_new_phys  = PW'(int_alloc_idx);
        ren_old_phys  = PW'(i_ra_phys);
        ren_old_valid = i_ra_vld;
      end
    end
  end

  assign lkp_phys  = log_is_fp(lkp_log) ? PW'(f_rb_phys) : PW'(i_rb_phys);
  assign lkp_valid = log_is_fp(lkp_log) ? f_rb_vld : i_rb_vld;

  // ---- ready scoreboards ----
  logic int_qry_rdy, fp_qry_rdy;

  rrm_scoreboard #(.N(NUM_INT_PHYS), .IW(IPW)) u_int_sb (
    .clk(clk), .rst_n(rst_n),
    .clr_en(alloc_int), .clr_idx(int_alloc_idx),
    .set_en(rdy_mark_valid & !rdy_mark_fp), .set_idx(IPW'(rdy_mark_phys)),
    .qry_idx(IPW'(rdy_qry_phys)), .qry_rdy(int_qry_rdy));

  rrm_scoreboard #(.N(NUM_FP_PHYS), .IW(FPW)) u_fp_sb (
    .clk(clk), .rst_n(rst_n),
    .clr_en(alloc_fp), .clr_idx(fp_alloc_idx),
    .set_en(rdy_mark_valid & rdy_mark_fp), .set_idx(FPW'(rdy_mark_phys)),
    .qry_idx(FPW'(rdy_qry_phys)), .qry_rdy(fp_qry_rdy));

  rrm_scoreboard #(.N(NUM_MISC), .IW(MW)) u_misc_sb (
    .clk(clk), .rst_n(rst_n),
    .clr_en(misc_clr_valid), .clr_idx(misc_clr_idx),
    .set_en(misc_set_valid), .set_idx(misc_set_idx),
    .qry_idx(misc_qry_idx), .qry_rdy(misc_qry_ready));

  assign rdy_qry_ready = rdy_qry_fp ? fp_qry_rdy : int_qry_rdy;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_stall && !sq_free_valid) |=> $stable(int_free_cnt) && $stable(fp_free_cnt));

  // R9
  sq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && sq_free_valid) |=> (int_free_cnt >= $past(int_free_cnt)) && (fp_free_cnt >= $past(fp_free_cnt)));

  // R2
  zero_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_zero && !sq_free_valid) |=> $stable(int_free_cnt) && $stable(fp_free_cnt));

  // R1
  one_class_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_go |=> ((int_free_cnt + ICW'(fp_free_cnt)) < ($past(int_free_cnt) + ICW'($past(fp_free_cnt)))));

endmodule

// File: tb/register_rename_map_tb.sv
module register_rename_map_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n;
  logic       ren_valid;
  logic [3:0] ren_log;
  logic       ren_stall;
  logic [3:0] ren_new_phys, ren_old_phys;
  logic       ren_old_valid;
  logic [3:0] lkp_log, lkp_phys;
  logic       lkp_valid;
  logic       set_valid;
  logic [3:0] set_log, set_phys;
  logic       rdy_mark_valid, rdy_mark_fp;
  logic [3:0] rdy_mark_phys;
  logic       rdy_qry_fp;
  logic [3:0] rdy_qry_phys;
  logic       rdy_qry_ready;
  logic       misc_set_valid, misc_clr_valid;
  logic [1:0] misc_set_idx, misc_clr_idx, misc_qry_idx;
  logic       misc_qry_ready;
  logic       sq_unmap_valid, sq_unmap_pvalid;
  logic [3:0] sq_unmap_log, sq_unmap_phys;
  logic       sq_free_valid, sq_free_fp;
  logic [3:0] sq_free_phys;
  logic [4:0] int_free_cnt, fp_free_cnt;

  register_rename_map u_dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [15:0] m_ifree, m_ffree, m_irdy, m_frdy;
  logic [3:0]  m_misc;
  int          m_phys [16];
  bit          m_vld  [16];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit is_zero(input int l);
    return (l == 0) || (l == 8);
  endfunction

  function automatic int lowest(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) if (v[i]) lowest = i;
    if (v == '0) lowest = 0;
  endfunction

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic model_reset();
    m_ifree = 16'hFFFE;
    m_ffree = 16'hFFFE;
    m_irdy  = '1;
    m_frdy  = '1;
    m_misc  = '1;
    for (int i = 0; i < 16; i++) begin
      m_phys[i] = 0;
      m_vld[i]  = 1'b0;
    end
  endtask

  task automatic idle();
    ren_valid = 0; ren_log = 0; lkp_log = 0;
    set_valid = 0; set_log = 0; set_phys = 0;
    rdy_mark_valid = 0; rdy_mark_fp = 0; rdy_mark_phys = 0;
    rdy_qry_fp = 0; rdy_qry_phys = 0;
    misc_set_valid = 0; misc_set_idx = 0; misc_clr_valid = 0; misc_clr_idx = 0; misc_qry_idx = 0;
    sq_unmap_valid = 0; sq_unmap_log = 0; sq_unmap_phys = 0; sq_unmap_pvalid = 0;
    sq_free_valid = 0; sq_free_fp = 0; sq_free_phys = 0;
  endtask

  // Called at a falling edge with inputs driven: compare, then advance one clock.
  task automatic step();
    int  l, np;
    bit  fp, z, blk, stall, go;
    #2;
    l     = int'(ren_log);
    fp    = l >= 8;
    z     = is_zero(l);
    blk   = sq_unmap_valid | sq_free_valid | set_valid;
    stall = ren_valid && (blk || (!z && (fp ? ones(m_ffree) : ones(m_ifree)) == 0));
    go    = ren_valid && !stall && !z;
    np    = fp ? lowest(m_ffree) : lowest(m_ifree);
    if (ren_valid) begin
      chk("R6 R9 rename stall", int'(ren_stall), int'(stall));
      if (!stall) begin
        chk("R1 R2 R3 new phys", int'(ren_new_phys), z ? 0 : np);
        chk("R1 R2 old phys", int'(ren_old_phys), m_phys[l]);
        chk("R1 R2 old valid", int'(ren_old_valid), int'(m_vld[l]));
      end
    end
    chk("R7 R10 R3 lookup phys", int'(lkp_phys), m_phys[lkp_log]);
    chk("R7 R10 R2 lookup valid", int'(lkp_valid), int'(m_vld[lkp_log]));
    chk("R5 ready query", int'(rdy_qry_ready),
        int'(rdy_qry_fp ? m_frdy[rdy_qry_phys] : m_irdy[rdy_qry_phys]));
    chk("R11 misc ready", int'(misc_qry_ready), int'(m_misc[misc_qry_idx]));
    chk("R12 R8 int free count", int'(int_free_cnt), ones(m_ifree));
    chk("R12 R8 fp free count", int'(fp_free_cnt), ones(m_ffree));
    @(posedge clk);
    if (go) begin
      if (fp) begin m_ffree[np] = 1'b0; m_frdy[np] = 1'b0; end
      else    begin m_ifree[np] = 1'b0; m_irdy[np] = 1'b0; end
      m_phys[l] = np;
      m_vld[l]  = 1'b1;
    end
    if (rdy_mark_valid) begin
      if (rdy_mark_fp) m_frdy[rdy_mark_phys] = 1'b1;
      else             m_irdy[rdy_mark_phys] = 1'b1;
    end
    if (set_valid && !is_zero(int'(set_log))) begin
      m_phys[set_log] = int'(set_phys);
      m_vld[set_log]  = 1'b1;
    end
    if (sq_unmap_valid && !is_zero(int'(sq_unmap_log))) begin
      m_phys[sq_unmap_log] = int'(sq_unmap_phys);
      m_vld[sq_unmap_log]  = sq_unmap_pvalid;
    end
    if (sq_free_valid && sq_free_phys != 0) begin
      if (sq_free_fp) m_ffree[sq_free_phys] = 1'b1;
      else            m_ifree[sq_free_phys] = 1'b1;
    end
    if (misc_clr_valid) m_misc[misc_clr_idx] = 1'b0;
    if (misc_set_valid) m_misc[misc_set_idx] = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    idle();
    model_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R4: state while held in reset
    lkp_log = 4'd3; rdy_qry_phys = 4'd5; #1;
    chk("R4 int free count", int'(int_free_cnt), 15);
    chk("R4 fp free count", int'(fp_free_cnt), 15);
    chk("R4 lookup invalid", int'(lkp_valid), 0);
    chk("R4 lookup phys", int'(lkp_phys), 0);
    chk("R4 ready", int'(rdy_qry_ready), 1);
    lkp_log = 4'd12; rdy_qry_fp = 1'b1; #1;
    chk("R4 fp lookup invalid", int'(lkp_valid), 0);
    chk("R4 fp ready", int'(rdy_qry_ready), 1);
    rst_n = 1'b1;
    idle();
    @(negedge clk);

    // R1 R3: rename every non-zero register of both classes
    for (int i = 1; i < 16; i++) begin
      if (i != 8) begin
        ren_valid = 1; ren_log = 4'(i); lkp_log = 4'(i - 1);
        rdy_qry_fp = (i > 8); rdy_qry_phys = 4'(i - 1);
        step();
      end
    end
    ren_valid = 0;
    for (int i = 0; i < 16; i++) begin
      lkp_log = 4'(i); rdy_qry_fp = i[0]; rdy_qry_phys = 4'(i);
      step();
    end

    // R2: zero registers
    ren_valid = 1; ren_log = 4'd0; step();
    ren_log = 4'd8; lkp_log = 4'd8; step();
    ren_valid = 0;

    // R5: mark ready, collide with allocation
    rdy_qry_fp = 0; rdy_qry_phys = 4'd1; step();
    rdy_mark_valid = 1; rdy_mark_phys = 4'd1; step();
    rdy_mark_valid = 0; step();
    rdy_mark_valid = 1; rdy_mark_fp = 1; rdy_mark_phys = 4'd3; rdy_qry_fp = 1; rdy_qry_phys = 4'd3; step();
    rdy_mark_valid = 0; step();
    // rename int: lowest free is 8; mark 8 in the same cycle (set wins)
    ren_valid = 1; ren_log = 4'd5; rdy_mark_valid = 1; rdy_mark_fp = 0; rdy_mark_phys = 4'd8;
    rdy_qry_fp = 0; rdy_qry_phys = 4'd8; step();
    rdy_mark_valid = 0; ren_valid = 0; step();

    // R6: drain integer pool
    for (int k = 0; k < 10; k++) begin
      ren_valid = 1; ren_log = 4'd3; lkp_log = 4'd3; rdy_qry_phys = 4'(9 + k);
      step();
    end

    // R9 R8: rename beside a return item; return of register 0
    ren_log = 4'd9; sq_free_valid = 1; sq_free_fp = 0; sq_free_phys = 4'd15; step();
    ren_log = 4'd2; sq_free_phys = 4'd0; step();
    sq_free_valid = 0; step();
    ren_valid = 0; step();

    // R7: restores, youngest first
    sq_unmap_valid = 1; sq_unmap_log = 4'd3; sq_unmap_phys = 4'd10; sq_unmap_pvalid = 1; lkp_log = 4'd3; step();
    sq_unmap_phys = 4'd4; step();
    sq_unmap_log = 4'd0; sq_unmap_phys = 4'd7; lkp_log = 4'd0; step();
    sq_unmap_log = 4'd10; sq_unmap_phys = 4'd0; sq_unmap_pvalid = 0; lkp_log = 4'd10; step();
    sq_unmap_valid = 0; ren_valid = 1; ren_log = 4'd10; step();
    ren_valid = 0; step();

    // R10: set-entry, including the zero register and a collision with rename
    set_valid = 1; set_log = 4'd6; set_phys = 4'd12; lkp_log = 4'd6; step();
    set_log = 4'd8; set_phys = 4'd5; lkp_log = 4'd8; step();
    set_log = 4'd7; set_phys = 4'd2; ren_valid = 1; ren_log = 4'd6; lkp_log = 4'd7; step();
    set_valid = 0; step();
    ren_valid = 0; lkp_log = 4'd6; step();

    // R7: restore and set on one class in one cycle
    sq_unmap_valid = 1; sq_unmap_log = 4'd4; sq_unmap_phys = 4'd6; sq_unmap_pvalid = 1;
    set_valid = 1; set_log = 4'd4; set_phys = 4'd9; lkp_log = 4'd4; step();
    sq_unmap_valid = 0; set_valid = 0; step();

    // R8: floating-point return then reuse
    sq_free_valid = 1; sq_free_fp = 1; sq_free_phys = 4'd2; step();
    sq_free_valid = 0; ren_valid = 1; ren_log = 4'd15; lkp_log = 4'd15; step();
    ren_valid = 0; step();

    // R11: miscellaneous scoreboard
    misc_clr_valid = 1; misc_clr_idx = 2'd2; misc_qry_idx = 2'd2; step();
    misc_clr_valid = 0; step();
    misc_clr_valid = 1; misc_clr_idx = 2'd1; misc_set_valid = 1; misc_set_idx = 2'd1; misc_qry_idx = 2'd1; step();
    misc_clr_valid = 0; misc_set_valid = 0; step();
    misc_set_valid = 1; misc_set_idx = 2'd2; misc_qry_idx = 2'd2; step();
    misc_set_valid = 0; misc_qry_idx = 2'd3; step();

    idle();
    step();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule